// File: doc/BRIEF.md
# Two-Wire Control Bus Router

This block sits on a host's two-wire control bus (SCL/SDA, I2C-style) and decides where the bus goes. There are three possible targets: an external configuration PROM, a display's DDC port, or a small local register file. The block samples the bus on a fast system clock and picks out START and STOP conditions and the address byte. It then opens the matching downstream path, or it answers the access itself.

After reset, traffic passes through to the PROM. When the local device address appears on the bus, the block shuts the PROM path before the acknowledge slot and serves the access from its own registers. From then on it stays in local mode. Writing a routing command into one local register picks the next pass-through target, either PROM or DDC. That choice takes effect at the STOP that ends the command transaction. While routed to the DDC port, the first STOP that follows a START hands the bus back to the local registers.

Each register write is also presented on a strobe/index/data interface to neighbouring logic.

Top module: `tw_bus_router`

## Requirements
- R1: After reset, prom_en is 1, ddc_en is 0, sda_pull is 0 and no write strobe is issued.
- R2: The local 7-bit address is {0,1,1,1,0,0,~strap_as}. The address byte is therefore 70h/71h when strap_as is 1 and 72h/73h when it is 0. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: In PROM mode, a matching address drops prom_en before the acknowledge slot. Routing then stays local (prom_en 0, ddc_en 0) after the STOP.
- R4: In PROM mode, a non-matching address leaves prom_en at 1. The block neither acknowledges nor writes anything.
- R5: In local mode, a non-matching address and its data bytes are not acknowledged and cause no register write.
- R6: In a local write, the first data byte is the register index. An index of 18 or more selects location 0. Each later byte is written to the current index with a one-cycle reg_wr_stb carrying reg_wr_idx and reg_wr_data. The index then advances, wrapping from 17 to 0. Every byte is acknowledged.
- R7: In a local read, bytes come out MSB first from the current index, and the index advances after each byte. It persists between transactions. A master NACK ends the read and releases SDA.
- R8: Writing location 10h selects the pass-through target: bit 0 = 1 selects DDC, bit 0 = 0 selects PROM. The new route takes effect only at the STOP that ends that transaction. Apart from an address claim, routing changes only on a STOP.
- R9: In DDC mode, ddc_en is 1 and the block does not answer even its own address. A STOP that follows a START returns routing to local (both enables 0).
- R10: In DDC mode, a STOP with no preceding START leaves routing unchanged.
- R11: The block's SDA drive changes only while SCL is low, or when a START or STOP resets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Host bus clock level |
| sda_in | input | 1 | Host bus data level (wired line) |
| strap_as | input | 1 | Address-select strap |
| prom_en | output | 1 | Enables the open-drain pass-through to the PROM pair |
| ddc_en | output | 1 | Enables the open-drain pass-through to the DDC pair |
| sda_pull | output | 1 | Local open-drain pull-down of SDA |
| reg_wr_stb | output | 1 | One-cycle local register write strobe |
| reg_wr_idx | output | IW | Index of the written register |
| reg_wr_data | output | 8 | Data of the written register |

## Verification
The bench aims at the moment of the claim from PROM mode. A router that decided after the acknowledge slot would still have prom_en high when SDA is sampled, so two targets would answer the same byte.

It drives index bytes past the end of the register space and writes across location 17. A design that kept a wrong index or missed the wrap would strobe the wrong location, which the read-back exposes.

Around the routing command, it checks enables before and after the STOP, and it sends a bare STOP in DDC mode. An eager route switch, or a return that fires on any STOP, would change the enables at the wrong time.

It also confirms that the block stays silent to its own address while in DDC mode.

// File: rtl/tw_router_pkg.sv
package tw_router_pkg;

  typedef enum logic [1:0] {
    RT_PROM  = 2'd0,
    RT_DDC   = 2'd1,
    RT_LOCAL = 2'd2
  } route_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_IDX    = 3'd2,
    PH_WDATA  = 3'd3,
    PH_RDATA  = 3'd4,
    PH_IGNORE = 3'd5
  } phase_e;

  // local 7-bit device address; strap high gives byte 70h
  function automatic logic [6:0] own_addr7(input logic strap);
    return {6'b011100, ~strap};
  endfunction

  // index advance with wrap at the end of the register space
  function automatic int unsigned wrap_next(input int unsigned i, input int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

  // an out-of-range index byte selects location 0
  function automatic int unsigned clamp_index(input int unsigned b, input int unsigned n);
    return (b >= n) ? 0 : b;
  endfunction

endpackage

// File: rtl/tw_bus_sense.sv
module tw_bus_sense #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC-2:0], sda_in};
      scl_p  <= scl_ff[SYNC-1];
      sda_p  <= sda_ff[SYNC-1];
    end
  end

  assign scl_s    = scl_ff[SYNC-1];
  assign sda_s    = sda_ff[SYNC-1];
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise_ev  = scl_s & ~scl_p;
  assign fall_ev  = ~scl_s & scl_p;

endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine
  import tw_router_pkg::*;
#(
  parameter int NREGS = 18,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          rise_ev,
  input  logic          fall_ev,
  input  logic [6:0]    own_addr,
  input  logic          allow_claim,
  input  logic [7:0]    rd_data,
  output logic [IW-1:0] idx_o,
  output logic          wr_stb,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          claim_ev,
  output logic          sda_drv
);
  phase_e      phase;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg, tx_q;
  logic        claimed, rw_q, ack_bit;
  logic [IW-1:0] idx_q;
  logic [7:0]  byte_in;
  logic        active;

  assign byte_in = {shreg[6:0], sda_s};
  assign active  = (phase != PH_IDLE) && (phase != PH_IGNORE);
  assign idx_o   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_q     <= '0;
      claimed  <= 1'b0;
      rw_q     <= 1'b0;
      ack_bit  <= 1'b1;
      idx_q    <= '0;
      wr_stb   <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      claim_ev <= 1'b0;
      sda_drv  <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      claim_ev <= 1'b0;
      if (start_ev) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        claimed <= 1'b0;
        sda_drv <= 1'b0;
      end else if (stop_ev) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        claimed <= 1'b0;
        sda_drv <= 1'b0;
      end else if (active && rise_ev) begin
        if (bit_cnt < 4'd8) begin
          shreg   <= byte_in;
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'd8) begin
          ack_bit <= sda_s;
          bit_cnt <= 4'd9;
        end
        if (bit_cnt == 4'd7) begin
          case (phase)
            PH_ADDR: begin
              if (byte_in[7:1] == own_addr && allow_claim) begin
                claimed  <= 1'b1;
                rw_q     <= byte_in[0];
                claim_ev <= 1'b1;
              end else begin
                phase <= PH_IGNORE;
              end
            end
            PH_IDX: begin
              idx_q <= IW'(clamp_index(32'(byte_in), NREGS));
              phase <= PH_WDATA;
            end
            PH_WDATA: begin
              wr_stb  <= 1'b1;
              wr_idx  <= idx_q;
              wr_data <= byte_in;
              idx_q   <= IW'(wrap_next(32'(idx_q), NREGS));
            end
            default: ;
          endcase
        end
      end else if (active && fall_ev) begin
        if (bit_cnt == 4'd8) begin
          sda_drv <= claimed && (phase != PH_RDATA);
        end else if (bit_cnt == 4'd9) begin
          bit_cnt <= '0;
          sda_drv <= 1'b0;
          case (phase)
            PH_ADDR: begin
              if (rw_q) begin
                phase   <= PH_RDATA;
                tx_q    <= rd_data;
                sda_drv <= ~rd_data[7];
                idx_q   <= IW'(wrap_next(32'(idx_q), NREGS));
              end else begin
                phase <= PH_IDX;
              end
            end
            PH_RDATA: begin
              if (!ack_bit) begin
                tx_q    <= rd_data;
                sda_drv <= ~rd_data[7];
                idx_q   <= IW'(wrap_next(32'(idx_q), NREGS));
              end else begin
                phase <= PH_IGNORE;
              end
            end
            default: ;
          endcase
        end else if (phase == PH_RDATA && bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
          tx_q    <= {tx_q[6:0], 1'b0};
          sda_drv <= ~tx_q[6];
        end
      end
    end
  end

  // R11
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_drv));

  // R5
  ack_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drv) |-> claimed);

endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank #(
  parameter int NREGS = 18,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data
);
  logic [7:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (wr_stb && wr_idx == IW'(g))     q <= wr_data;
    end
    assign regs[g] = q;
  end

  assign rd_data = regs[rd_idx];

  // R6
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> regs[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/tw_route_ctl.sv
module tw_route_ctl
  import tw_router_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_ev,
  input  logic stop_ev,
  input  logic claim_ev,
  input  logic cmd_wr,
  input  logic cmd_ddc,
  output logic allow_claim,
  output logic prom_en,
  output logic ddc_en
);
  route_e route_q, pend_q;
  logic   pend_v, seen_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q    <= RT_PROM;
      pend_q     <= RT_PROM;
      pend_v     <= 1'b0;
      seen_start <= 1'b0;
    end else begin
      if (start_ev) seen_start <= 1'b1;
      if (cmd_wr) begin
        pend_q <= cmd_ddc ? RT_DDC : RT_PROM;
        pend_v <= 1'b1;
      end
      if (claim_ev && route_q == RT_PROM) route_q <= RT_LOCAL;
      if (stop_ev) begin
        seen_start <= 1'b0;
        if (pend_v) begin
          route_q <= pend_q;
          pend_v  <= 1'b0;
        end else if (route_q == RT_DDC && seen_start) begin
          route_q <= RT_LOCAL;
        end
      end
    end
  end

  assign allow_claim = (route_q != RT_DDC);
  assign prom_en     = (route_q == RT_PROM);
  assign ddc_en      = (route_q == RT_DDC);

  // R3
  claim_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_ev && prom_en) |=> (!prom_en && !ddc_en));

  // R8
  route_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_ev && !claim_ev) |=> $stable(route_q));

  // R9
  ddc_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ddc_en && stop_ev && seen_start && !pend_v) |=> (!ddc_en && !prom_en));

  // R10
  ddc_bare_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ddc_en && stop_ev && !seen_start && !pend_v) |=> ddc_en);

endmodule

// File: rtl/tw_bus_router.sv
module tw_bus_router
  import tw_router_pkg::*;
#(
  parameter  int NREGS     = 18,
  parameter  int ROUTE_IDX = 16,
  parameter  int SYNC      = 2,
  localparam int IW        = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          strap_as,
  output logic          prom_en,
  output logic          ddc_en,
  output logic          sda_pull,
  output logic          reg_wr_stb,
  output logic [IW-1:0] reg_wr_idx,
  output logic [7:0]    reg_wr_data
);
  logic scl_s, sda_s, start_ev, stop_ev, rise_ev, fall_ev;
  logic allow_claim, claim_ev, cmd_wr;
  logic [IW-1:0] cur_idx;
  logic [7:0]    rd_data;

  tw_bus_sense #(.SYNC(SYNC)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  tw_byte_engine #(.NREGS(NREGS), .IW(IW)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .own_addr(own_addr7(strap_as)), .allow_claim(allow_claim), .rd_data(rd_data),
    .idx_o(cur_idx), .wr_stb(reg_wr_stb), .wr_idx(reg_wr_idx), .wr_data(reg_wr_data),
    .claim_ev(claim_ev), .sda_drv(sda_pull)
  );

  tw_reg_bank #(.NREGS(NREGS), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(reg_wr_stb), .wr_idx(reg_wr_idx),
    .wr_data(reg_wr_data), .rd_idx(cur_idx), .rd_data(rd_data)
  );

  assign cmd_wr = reg_wr_stb && (reg_wr_idx == IW'(ROUTE_IDX));

  tw_route_ctl u_route (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .claim_ev(claim_ev), .cmd_wr(cmd_wr), .cmd_ddc(reg_wr_data[0]),
    .allow_claim(allow_claim), .prom_en(prom_en), .ddc_en(ddc_en)
  );

  // R1
  reset_route_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (prom_en && !ddc_en && !sda_pull));

endmodule

// File: tb/tw_bus_router_bench.sv
module tw_bus_router_bench;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, strap = 1'b1;
  logic prom_en, ddc_en, sda_pull, reg_wr_stb;
  logic [4:0] reg_wr_idx;
  logic [7:0] reg_wr_data;
  logic sda_line;

  always #2 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  tw_bus_router u_tw_bus_router (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .strap_as(strap),
    .prom_en(prom_en), .ddc_en(ddc_en), .sda_pull(sda_pull),
    .reg_wr_stb(reg_wr_stb), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data)
  );

  int total = 0, bad = 0, n_wr = 0;
  logic [4:0] log_idx [64];
  logic [7:0] log_dat [64];

  always @(posedge clk) if (reg_wr_stb) begin
    log_idx[n_wr % 64] <= reg_wr_idx;
    log_dat[n_wr % 64] <= reg_wr_data;
    n_wr <= n_wr + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wt(H/2); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    wt(H/2); m_sda = 1'b0; wt(H/2); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic ack_early,
                           output logic pa, output logic da);
    for (int i = 7; i >= 0; i--) begin
      wt(H/2); m_sda = b[i]; wt(H/2); m_scl = 1'b1; wt(H); m_scl = 1'b0;
    end
    wt(H/2); m_sda = 1'b1; wt(H/2); m_scl = 1'b1;
    wt(1); ack_early = sda_line;
    wt(H/2 - 1); ack = sda_line; pa = prom_en; da = ddc_en;
    wt(H/2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); m_scl = 1'b1; wt(H/2); b[i] = sda_line; wt(H/2); m_scl = 1'b0;
    end
    wt(H/2); m_sda = nack; wt(H/2); m_scl = 1'b1; wt(H); m_scl = 1'b0;
    wt(H/2); m_sda = 1'b1;
  endtask

  logic a, ae, pa, da;
  logic [7:0] rb;
  int base;

  task automatic t_reset;
    wt(5); rst_n = 1'b1; wt(5);
    chk("R1 prom_en", int'(prom_en), 1);
    chk("R1 ddc_en", int'(ddc_en), 0);
    chk("R1 sda_pull", int'(sda_pull), 0);
    chk("R1 strobes", n_wr, 0);
  endtask

  task automatic t_foreign_prom;
    base = n_wr;
    bus_start; send_byte(8'hA0, a, ae, pa, da);
    chk("R4 no ack", int'(a), 1); chk("R4 prom kept", int'(pa), 1);
    send_byte(8'h55, a, ae, pa, da); chk("R4 data no ack", int'(a), 1);
    bus_stop;
    chk("R4 prom after", int'(prom_en), 1); chk("R4 no write", n_wr - base, 0);
  endtask

  task automatic t_claim;
    base = n_wr;
    bus_start; send_byte(8'h70, a, ae, pa, da);
    chk("R2 ack 70h", int'(a), 0); chk("R3 prom cut at ack", int'(pa), 0);
    chk("R11 ack steady", int'(ae), int'(a));
    send_byte(8'h03, a, ae, pa, da); chk("R6 index ack", int'(a), 0);
    send_byte(8'h5A, a, ae, pa, da); chk("R6 data ack", int'(a), 0);
    send_byte(8'hC3, a, ae, pa, da); chk("R11 data ack steady", int'(ae), 0);
    bus_stop;
    chk("R3 prom off", int'(prom_en), 0); chk("R3 ddc off", int'(ddc_en), 0);
    chk("R6 two writes", n_wr - base, 2);
    chk("R6 idx0", int'(log_idx[base % 64]), 3); chk("R6 dat0", int'(log_dat[base % 64]), 8'h5A);
    chk("R6 idx1", int'(log_idx[(base + 1) % 64]), 4); chk("R6 dat1", int'(log_dat[(base + 1) % 64]), 8'hC3);
  endtask

  task automatic t_read;
    base = n_wr;
    bus_start; send_byte(8'h70, a, ae, pa, da); send_byte(8'h03, a, ae, pa, da);
    bus_start; send_byte(8'h71, a, ae, pa, da); chk("R7 read addr ack", int'(a), 0);
    recv_byte(1'b0, rb); chk("R7 byte0", int'(rb), 8'h5A);
    recv_byte(1'b1, rb); chk("R7 byte1", int'(rb), 8'hC3);
    chk("R7 released after nack", int'(sda_pull), 0);
    bus_stop;
    bus_start; send_byte(8'h71, a, ae, pa, da);
    recv_byte(1'b1, rb); chk("R7 index persists", int'(rb), 8'h00);
    bus_stop;
    chk("R7 no write", n_wr - base, 0);
  endtask

  task automatic t_wrap;
    base = n_wr;
    bus_start; send_byte(8'h70, a, ae, pa, da); send_byte(8'h11, a, ae, pa, da);
    send_byte(8'h77, a, ae, pa, da); send_byte(8'h88, a, ae, pa, da); bus_stop;
    chk("R6 last loc", int'(log_idx[base % 64]), 17);
    chk("R6 wrap to 0", int'(log_idx[(base + 1) % 64]), 0);
    bus_start; send_byte(8'h70, a, ae, pa, da); send_byte(8'h25, a, ae, pa, da);
    send_byte(8'h19, a, ae, pa, da); bus_stop;
    chk("R6 clamp idx", int'(log_idx[(base + 2) % 64]), 0);
    bus_start; send_byte(8'h70, a, ae, pa, da); send_byte(8'h11, a, ae, pa, da);
    bus_start; send_byte(8'h71, a, ae, pa, da);
    recv_byte(1'b0, rb); chk("R7 read loc17", int'(rb), 8'h77);
    recv_byte(1'b1, rb); chk("R7 read wrapped loc0", int'(rb), 8'h19);
    bus_stop;
  endtask

  task automatic t_foreign_local;
    base = n_wr;
    bus_start; send_byte(8'hA0, a, ae, pa, da); chk("R5 no ack", int'(a), 1);
    send_byte(8'h00, a, ae, pa, da); chk("R5 data no ack", int'(a), 1);
    bus_stop;
    chk("R5 no write", n_wr - base, 0); chk("R5 prom stays off", int'(prom_en), 0);
  endtask

  task automatic t_strap;
    strap = 1'b0; wt(4);
    bus_start; send_byte(8'h70, a, ae, pa, da); bus_stop;
    chk("R2 70h ignored strap low", int'(a), 1);
    bus_start; send_byte(8'h72, a, ae, pa, da); bus_stop;
    chk("R2 72h ack strap low", int'(a), 0);
  endtask

  task automatic t_to_ddc;
    base = n_wr;
    bus_start; send_byte(8'h72, a, ae, pa, da); send_byte(8'h10, a, ae, pa, da);
    send_byte(8'h01, a, ae, pa, da); wt(H);
    chk("R8 not before stop", int'(ddc_en), 0);
    bus_stop;
    chk("R8 ddc on", int'(ddc_en), 1); chk("R8 prom off", int'(prom_en), 0);
    chk("R6 route write idx", int'(log_idx[base % 64]), 16);
  endtask

  task automatic t_ddc_bare_stop;
    m_scl = 1'b0; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
    chk("R10 ddc kept", int'(ddc_en), 1);
  endtask

  task automatic t_ddc_txn;
    base = n_wr;
    bus_start; send_byte(8'h72, a, ae, pa, da);
    chk("R9 own addr silent", int'(a), 1); chk("R9 ddc during", int'(da), 1);
    send_byte(8'h00, a, ae, pa, da); bus_stop;
    chk("R9 ddc off", int'(ddc_en), 0); chk("R9 prom off", int'(prom_en), 0);
    chk("R9 no write", n_wr - base, 0);
  endtask

  task automatic t_to_prom;
    bus_start; send_byte(8'h72, a, ae, pa, da); send_byte(8'h10, a, ae, pa, da);
    send_byte(8'h00, a, ae, pa, da); wt(H);
    chk("R8 prom not before stop", int'(prom_en), 0);
    bus_stop;
    chk("R8 prom on", int'(prom_en), 1); chk("R8 ddc stays off", int'(ddc_en), 0);
  endtask

  initial begin
    t_reset;
    t_foreign_prom;
    t_claim;
    t_read;
    t_wrap;
    t_foreign_local;
    t_strap;
    t_to_ddc;
    t_ddc_bare_stop;
    t_ddc_txn;
    t_to_prom;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule